// File: doc/BRIEF.md
# Dual-Enable Static RAM Functional Model

This block is a synthesizable, cycle-sampled stand-in for an asynchronous static RAM of 8192 bytes, meant to sit on the memory side of a testbench or an emulation build. A fast free-running clock samples the pins: a 13-bit address, an active-low select, an active-high select, an active-low write strobe and an active-low read strobe. The tri-state data bus is split into a data input, a data output and an output-drive flag.

Each sample is sorted into one of four modes. The modes are standby (either select inactive), selected-idle, read and write. A write is not tied to a clock edge of its own. The byte is stored when the write condition ends, whichever of the three terminating pins ends it. The stored data and address are the ones held in the last sample of the write. A sticky flag reports an address that moved while a write was still open.

Top module: `dual_enable_sram_model`

## Requirements
- R1: When `en_lo_n` is 1 or `en_hi` is 0 (standby), `dout_en` is 0 after that sample edge, whatever `wr_n` and `rd_n` are, and no write is begun or stored.
- R2: With both selects active and `wr_n`=1, `rd_n`=1, `dout_en` is 0 after that sample edge.
- R3: With both selects active, `wr_n`=1 and `rd_n`=0, after that sample edge `dout_en` is 1 and `dout` holds the byte stored at `addr`.
- R4: With both selects active and `wr_n`=0, `dout_en` is 0 after that sample edge, whatever `rd_n` is.
- R5: A write ended by `wr_n` going to 1 stores, at that edge, the `din` and `addr` seen in the last sample of the write.
- R6: A write ended by `en_lo_n` going to 1 stores the same way as R5.
- R7: A write ended by `en_hi` going to 0 stores the same way as R5.
- R8: All 8192 addresses, 0 through 8191, are separate byte locations.
- R9: `addr_viol` goes to 1 when the write condition holds in two successive samples with different `addr` values. It then stays 1 until reset.
- R10: While `rst_n` is 0 and right after it, `dout_en` and `addr_viol` are 0, and no write is in progress.
- R11: A read in the sample that ends a write to the same address returns the newly stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Word address |
| en_lo_n | input | 1 | Active-low select |
| en_hi | input | 1 | Active-high select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read (output) strobe |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_en | output | 1 | Bus-drive flag, 1 when `dout` is driven |
| addr_viol | output | 1 | Sticky flag: address moved during a write |

## Verification
Two functions can fall into one sample: a write commit and a read of the same address. They meet when the write strobe rises while the read strobe is already low. Directed cases raise `wr_n` with `rd_n` held low at an unchanged address. The byte returned in that very sample is judged against the freshly written value. The random phase mixes all four modes over a small address pool, so this overlap recurs. It also recurs together with terminations by either select. Every such read is compared with a bench model that applies the commit before the read.

// File: rtl/sram_model_pkg.sv
`timescale 1ns/1ps
package sram_model_pkg;

    // Pin-level operating mode of one sample
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_IDLE    = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode
    import sram_model_pkg::*;
(
    input  logic       en_lo_n,
    input  logic       en_hi,
    input  logic       wr_n,
    input  logic       rd_n,
    output sram_mode_e mode
);

    always_comb begin
        if (en_lo_n || !en_hi) begin
            mode = MODE_STANDBY;
        end else if (!wr_n) begin
            mode = MODE_WRITE;
        end else if (!rd_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_IDLE;
        end
    end

endmodule

// File: rtl/sram_write_tracker.sv
`timescale 1ns/1ps
module sram_write_tracker
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_mode_e        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              addr_viol
);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              viol;
    } trk_t;

    trk_t trk_d, trk_q;
    logic wr_now;

    always_comb begin
        wr_now        = (mode == MODE_WRITE);
        trk_d         = trk_q;
        trk_d.wr      = wr_now;
        trk_d.addr    = addr;
        trk_d.data    = din;
        if (trk_q.wr && wr_now && (addr != trk_q.addr)) begin
            trk_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // Falling edge of the registered write term ends the write
    assign commit      = trk_q.wr && !wr_now;
    assign commit_addr = trk_q.addr;
    assign commit_data = trk_q.data;
    assign addr_viol   = trk_q.viol;

    assert_viol_sticky_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        addr_viol |=> addr_viol
    ) else $error("R9: violation flag cleared without reset");

    assert_commit_single_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        commit |=> !commit
    ) else $error("R5: write committed in two consecutive samples");

endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // A commit landing in the same sample as a read is forwarded
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) begin
            rd_data = wr_data;
        end else begin
            rd_data = mem[rd_addr];
        end
    end

endmodule

// File: rtl/dual_enable_sram_model.sv
`timescale 1ns/1ps
module dual_enable_sram_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_lo_n,
    input  logic              en_hi,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              addr_viol
);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] data;
    } out_t;

    sram_mode_e        mode;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] rd_data;
    out_t              out_d, out_q;

    sram_mode_decode u_decode (
        .en_lo_n (en_lo_n),
        .en_hi   (en_hi),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .mode    (mode)
    );

    sram_write_tracker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .addr        (addr),
        .din         (din),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .addr_viol   (addr_viol)
    );

    sram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    always_comb begin
        out_d    = out_q;
        out_d.en = (mode == MODE_READ);
        if (mode == MODE_READ) begin
            out_d.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout    = out_q.data;
    assign dout_en = out_q.en;

    assert_standby_hiz_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (en_lo_n || !en_hi) |=> !dout_en
    ) else $error("R1: bus driven after standby sample");

    assert_idle_hiz_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!en_lo_n && en_hi && wr_n && rd_n) |=> !dout_en
    ) else $error("R2: bus driven with both strobes high");

    assert_read_drive_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!en_lo_n && en_hi && wr_n && !rd_n) |=> dout_en
    ) else $error("R3: bus not driven on read sample");

    assert_write_hiz_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!en_lo_n && en_hi && !wr_n) |=> !dout_en
    ) else $error("R4: bus driven during write");

endmodule

// File: tb/dual_enable_sram_model_test.sv
`timescale 1ns/1ps
module dual_enable_sram_model_test;

    localparam int AW    = 13;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          en_lo_n, en_hi, wr_n, rd_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en, addr_viol;

    always #2.5 clk = ~clk;

    dual_enable_sram_model #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .en_lo_n(en_lo_n),
        .en_hi(en_hi), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .dout(dout), .dout_en(dout_en), .addr_viol(addr_viol)
    );

    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_ok  [DEPTH];
    bit            prev_wr, ref_viol;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] prev_din;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // 0 standby, 1 idle, 2 read, 3 write
    function automatic int mode_of(input logic lo_n, input logic hi, input logic w_n, input logic r_n);
        if (lo_n || !hi) return 0;
        if (!w_n)        return 3;
        if (!r_n)        return 2;
        return 1;
    endfunction

    function automatic string en_tag(input int m);
        case (m)
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic cycle(input logic [AW-1:0] a, input logic lo_n, input logic hi,
                         input logic w_n, input logic r_n, input logic [DW-1:0] d,
                         input string dtag = "R3");
        int  m;
        bit  wr;
        @(negedge clk);
        addr = a; en_lo_n = lo_n; en_hi = hi; wr_n = w_n; rd_n = r_n; din = d;
        @(posedge clk);
        #1;
        m  = mode_of(lo_n, hi, w_n, r_n);
        wr = (m == 3);
        if (prev_wr && !wr) begin
            ref_mem[prev_addr] = prev_din;
            ref_ok[prev_addr]  = 1'b1;
        end
        if (prev_wr && wr && (a != prev_addr)) ref_viol = 1'b1;
        prev_wr = wr; prev_addr = a; prev_din = d;
        check(en_tag(m), dout_en, (m == 2));
        if (m == 2 && ref_ok[a]) check(dtag, dout, ref_mem[a]);
        check("R9", addr_viol, ref_viol);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_lo_n = 1'b1; en_hi = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R10", dout_en, 0);
        check("R10", addr_viol, 0);
        @(negedge clk);
        rst_n = 1'b1;
        prev_wr = 1'b0;
        ref_viol = 1'b0;
        #1;
        check("R10", dout_en, 0);
        check("R10", addr_viol, 0);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; din = '0;
        en_lo_n = 1'b1; en_hi = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        prev_wr = 1'b0; ref_viol = 1'b0; prev_addr = '0; prev_din = '0;
        void'($urandom(32'd4242));
        do_reset();

        // R5 and R11: write closed by the write strobe, read in the same sample
        cycle(13'd5, 0, 1, 1, 1, 8'h00);
        cycle(13'd5, 0, 1, 0, 1, 8'hA5);
        cycle(13'd5, 0, 1, 0, 0, 8'hA5);
        cycle(13'd5, 0, 1, 1, 0, 8'h00, "R11");
        cycle(13'd5, 0, 1, 1, 0, 8'h00, "R5");

        // R6: write closed by the active-low select
        cycle(13'd9, 0, 1, 0, 1, 8'h3C);
        cycle(13'd9, 0, 1, 0, 1, 8'h3C);
        cycle(13'd9, 1, 1, 0, 1, 8'hFF);
        cycle(13'd9, 0, 1, 1, 0, 8'h00, "R6");

        // R7: write closed by the active-high select
        cycle(13'd10, 0, 1, 0, 1, 8'hC3);
        cycle(13'd10, 0, 1, 0, 1, 8'hC3);
        cycle(13'd10, 0, 0, 0, 1, 8'hFF);
        cycle(13'd10, 0, 1, 1, 0, 8'h00, "R7");

        // R1: write strobe in standby stores nothing
        cycle(13'd5, 1, 1, 0, 0, 8'h11);
        cycle(13'd5, 0, 0, 0, 0, 8'h22);
        cycle(13'd5, 1, 1, 1, 1, 8'h00);
        cycle(13'd5, 0, 1, 1, 0, 8'h00, "R1");

        // R8: both ends of the address range
        cycle(13'd0,    0, 1, 0, 1, 8'h5A);
        cycle(13'd0,    0, 1, 1, 1, 8'h00);
        cycle(13'd8191, 0, 1, 0, 1, 8'hE7);
        cycle(13'd8191, 0, 1, 1, 1, 8'h00);
        cycle(13'd0,    0, 1, 1, 0, 8'h00, "R8");
        cycle(13'd8191, 0, 1, 1, 0, 8'h00, "R8");
        cycle(13'd4096, 0, 1, 0, 1, 8'h81);
        cycle(13'd4096, 0, 1, 1, 0, 8'h00, "R8");
        cycle(13'd0,    0, 1, 1, 0, 8'h00, "R8");

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            if ($urandom % 4 == 0) a = AW'($urandom);
            else                   a = AW'(($urandom % 8) * 37);
            cycle(a, ($urandom % 8 == 0), ($urandom % 8 != 0),
                  ($urandom % 3 != 0), 1'($urandom % 2), DW'($urandom));
        end

        // R9: address moved during an open write, flag holds until reset
        do_reset();
        cycle(13'd20, 0, 1, 0, 1, 8'h01);
        cycle(13'd20, 0, 1, 0, 1, 8'h01);
        cycle(13'd21, 0, 1, 0, 1, 8'h02);
        cycle(13'd21, 0, 1, 1, 1, 8'h00);
        cycle(13'd22, 1, 0, 1, 1, 8'h00);
        cycle(13'd21, 0, 1, 1, 0, 8'h00, "R5");
        do_reset();
        cycle(13'd21, 0, 1, 1, 0, 8'h00, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule